// File: doc/BRIEF.md
# Byte/Word Host Port Controller

This block sits between a host bus and a sixteen-entry byte register memory. It holds no data itself. From the host's mode enables, the byte/word select, the read/write select and a four-bit address, it works out three things for each of the two 8-bit data lanes: which byte each lane reaches, whether that lane may write, and whether that lane may drive the bus. Lane A always reaches an even byte and lane B always reaches an odd byte.

The port has three modes.

- **Disabled:** the port is silent.
- **Addressed transfer (programmed I/O):** the host names a byte, or in word mode a byte pair.
- **Fixed-location transfer (DMA):** only the address LSB counts. It chooses between the two topmost byte pairs, or in byte mode between the two topmost bytes.

A lock input keeps host writes away from the two topmost bytes. A write strobe that is held high produces exactly one clock of write enable.

Top module: `host_port_ctl`

## Requirements
- R1: With `pio_en_n`=1 and `dma_en_n`=1 the port is disabled, and all four lane enables (`lane_a_oe`, `lane_b_oe`, `lane_a_we`, `lane_b_we`) stay 0.
- R2: `dma_en_n`=0 selects the fixed-location mode whatever the value of `pio_en_n`. `pio_en_n`=0 with `dma_en_n`=1 selects the addressed mode.
- R3: In addressed byte mode (`host_byte`=1), `host_addr[0]`=0 sends byte `host_addr` to lane A only, and `host_addr[0]`=1 sends byte `host_addr` to lane B only. The other lane neither drives nor writes.
- R4: In addressed word mode (`host_byte`=0), `host_addr[0]` is ignored. Lane A reaches byte {`host_addr[3:1]`,0} and lane B reaches the next odd byte, and both lanes take part.
- R5: In fixed byte mode, `host_addr[3:1]` is ignored. `host_addr[0]`=0 reaches byte 14 on lane A only, and `host_addr[0]`=1 reaches byte 15 on lane B only.
- R6: In fixed word mode, `host_addr[3:1]` is ignored. `host_addr[0]`=0 reaches bytes 12 and 13, and `host_addr[0]`=1 reaches bytes 14 and 15, on lanes A and B.
- R7: A lane's output enable is 1 only while `host_rd`=1 (read), the port is in an active mode, and that lane is selected.
- R8: A lane's write enable is 1 only while `host_rd`=0, the port is active, the lane is selected and `xfer_stb` is high. It lasts one clock per rising `xfer_stb`, however long the strobe is held.
- R9: With `wr_lock_hi`=1, no write enable reaches bytes 14 or 15. Writes to all other bytes are unaffected.
- R10: `lane_a_addr` is always even and `lane_b_addr` is always odd, with the same upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the strobe edge register |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_byte | input | 1 | 1 = byte transfer, 0 = word transfer |
| host_rd | input | 1 | 1 = read, 0 = write |
| pio_en_n | input | 1 | Addressed-mode enable, active low |
| dma_en_n | input | 1 | Fixed-location-mode enable, active low, has priority |
| host_addr | input | 4 | Host byte address |
| xfer_stb | input | 1 | Write transfer strobe |
| wr_lock_hi | input | 1 | 1 = block writes to bytes 14 and 15 |
| lane_a_addr | output | 4 | Byte reached by lane A (even) |
| lane_b_addr | output | 4 | Byte reached by lane B (odd) |
| lane_a_we | output | 1 | Lane A write enable |
| lane_b_we | output | 1 | Lane B write enable |
| lane_a_oe | output | 1 | Lane A output enable |
| lane_b_oe | output | 1 | Lane B output enable |

## Verification
Lane steering and the write lock act in the same cycle whenever a word write spans a locked pair. The bench provokes this case in three ways:

- an addressed word write to pair 14/15 with the lock set;
- a fixed word write with LSB 0 under the lock, which must still reach bytes 12 and 13;
- a byte write to an unlocked byte under the lock.

Each case is judged first at the per-lane write enables. It is then judged again by reading the bytes back through the port from the bench's byte array.

// File: rtl/hp_pkg.sv
package hp_pkg;
   typedef enum logic [1:0] {
      HP_OFF = 2'd0,
      HP_PIO = 2'd1,
      HP_DMA = 2'd2
   } hp_mode_e;
endpackage

// File: rtl/hp_mode_dec.sv
module hp_mode_dec
   import hp_pkg::*;
(
   input  logic     pio_en_n,
   input  logic     dma_en_n,
   output hp_mode_e mode
);
   always_comb begin
      if (!dma_en_n)      mode = HP_DMA;
      else if (!pio_en_n) mode = HP_PIO;
      else                mode = HP_OFF;
   end
endmodule

// File: rtl/hp_lane_map.sv
module hp_lane_map
   import hp_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  hp_mode_e          mode,
   input  logic              byte_mode,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] a_addr,
   output logic [ADDR_W-1:0] b_addr,
   output logic              sel_a,
   output logic              sel_b
);
   localparam int PAIR_W = ADDR_W - 1;

   logic [PAIR_W-1:0] pair;
   logic [PAIR_W-1:0] fixed_pair;

   // fixed pairs live at the top of the space; the LSB picks the upper one,
   // and byte mode always uses the uppermost pair
   assign fixed_pair = {{(PAIR_W-1){1'b1}}, byte_mode | addr[0]};

   always_comb begin
      pair  = addr[ADDR_W-1:1];
      sel_a = 1'b0;
      sel_b = 1'b0;
      unique case (mode)
         HP_PIO: begin
            pair  = addr[ADDR_W-1:1];
            sel_a = !byte_mode || !addr[0];
            sel_b = !byte_mode ||  addr[0];
         end
         HP_DMA: begin
            pair  = fixed_pair;
            sel_a = !byte_mode || !addr[0];
            sel_b = !byte_mode ||  addr[0];
         end
         default: begin
            pair  = addr[ADDR_W-1:1];
            sel_a = 1'b0;
            sel_b = 1'b0;
         end
      endcase
   end

   assign a_addr = {pair, 1'b0};
   assign b_addr = {pair, 1'b1};
endmodule

// File: rtl/hp_strobe_gen.sv
module hp_strobe_gen
   import hp_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter bit WP_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  hp_mode_e          mode,
   input  logic              rd,
   input  logic              stb,
   input  logic              lock,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic              sel_a,
   input  logic              sel_b,
   output logic              we_a,
   output logic              we_b,
   output logic              oe_a,
   output logic              oe_b
);
   logic stb_q;
   logic first;
   logic active;
   logic prot_a;
   logic prot_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q <= 1'b0;
      else        stb_q <= stb;
   end

   assign first  = stb && !stb_q;
   assign active = (mode != HP_OFF);

   generate
      if (WP_ENABLE) begin : g_lock
         assign prot_a = lock && (&a_addr[ADDR_W-1:1]);
         assign prot_b = lock && (&b_addr[ADDR_W-1:1]);
      end else begin : g_nolock
         assign prot_a = 1'b0;
         assign prot_b = 1'b0;
      end
   endgenerate

   assign oe_a = active && rd && sel_a;
   assign oe_b = active && rd && sel_b;
   assign we_a = active && !rd && first && sel_a && !prot_a;
   assign we_b = active && !rd && first && sel_b && !prot_b;
endmodule

// File: rtl/host_port_ctl.sv
module host_port_ctl
   import hp_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter bit WP_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_byte,
   input  logic              host_rd,
   input  logic              pio_en_n,
   input  logic              dma_en_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              xfer_stb,
   input  logic              wr_lock_hi,
   output logic [ADDR_W-1:0] lane_a_addr,
   output logic [ADDR_W-1:0] lane_b_addr,
   output logic              lane_a_we,
   output logic              lane_b_we,
   output logic              lane_a_oe,
   output logic              lane_b_oe
);
   generate
      if (ADDR_W < 3) begin : g_bad_addr_w
         $error("host_port_ctl: ADDR_W must be at least 3");
      end
   endgenerate

   hp_mode_e mode;
   logic     sel_a;
   logic     sel_b;

   hp_mode_dec u_mode (
      .pio_en_n (pio_en_n),
      .dma_en_n (dma_en_n),
      .mode     (mode)
   );

   hp_lane_map #(.ADDR_W(ADDR_W)) u_map (
      .mode      (mode),
      .byte_mode (host_byte),
      .addr      (host_addr),
      .a_addr    (lane_a_addr),
      .b_addr    (lane_b_addr),
      .sel_a     (sel_a),
      .sel_b     (sel_b)
   );

   hp_strobe_gen #(.ADDR_W(ADDR_W), .WP_ENABLE(WP_ENABLE)) u_stb (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode),
      .rd     (host_rd),
      .stb    (xfer_stb),
      .lock   (wr_lock_hi),
      .a_addr (lane_a_addr),
      .b_addr (lane_b_addr),
      .sel_a  (sel_a),
      .sel_b  (sel_b),
      .we_a   (lane_a_we),
      .we_b   (lane_b_we),
      .oe_a   (lane_a_oe),
      .oe_b   (lane_b_oe)
   );
endmodule

// File: rtl/hp_chk.sv
module hp_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_byte,
   input logic              host_rd,
   input logic              pio_en_n,
   input logic              dma_en_n,
   input logic [ADDR_W-1:0] host_addr,
   input logic              xfer_stb,
   input logic              wr_lock_hi,
   input logic [ADDR_W-1:0] lane_a_addr,
   input logic [ADDR_W-1:0] lane_b_addr,
   input logic              lane_a_we,
   input logic              lane_b_we,
   input logic              lane_a_oe,
   input logic              lane_b_oe
);
   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (pio_en_n && dma_en_n) |-> !(lane_a_oe || lane_b_oe || lane_a_we || lane_b_we)); // R1

   AST_DMA_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en_n |-> (&lane_a_addr[ADDR_W-1:2])); // R2

   AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      host_byte |-> ($countones({lane_a_oe, lane_b_oe, lane_a_we, lane_b_we}) <= 1)); // R3

   AST_NO_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |-> !(lane_a_oe || lane_b_oe)); // R7

   AST_NO_WE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd || !xfer_stb) |-> !(lane_a_we || lane_b_we)); // R8

   AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_a_we || lane_b_we) |=> !(lane_a_we || lane_b_we)); // R8

   AST_LOCK_A: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lock_hi && (&lane_a_addr[ADDR_W-1:1])) |-> !lane_a_we); // R9

   AST_LOCK_B: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lock_hi && (&lane_b_addr[ADDR_W-1:1])) |-> !lane_b_we); // R9

   AST_LANE_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (!lane_a_addr[0] && lane_b_addr[0] &&
       (lane_a_addr[ADDR_W-1:1] == lane_b_addr[ADDR_W-1:1]))); // R10
endmodule

bind host_port_ctl hp_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_byte   (host_byte),
   .host_rd     (host_rd),
   .pio_en_n    (pio_en_n),
   .dma_en_n    (dma_en_n),
   .host_addr   (host_addr),
   .xfer_stb    (xfer_stb),
   .wr_lock_hi  (wr_lock_hi),
   .lane_a_addr (lane_a_addr),
   .lane_b_addr (lane_b_addr),
   .lane_a_we   (lane_a_we),
   .lane_b_we   (lane_b_we),
   .lane_a_oe   (lane_a_oe),
   .lane_b_oe   (lane_b_oe)
);

// File: tb/sim_host_port_ctl.sv
module sim_host_port_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_byte = 1'b1;
   logic       host_rd = 1'b1;
   logic       pio_en_n = 1'b1;
   logic       dma_en_n = 1'b1;
   logic [3:0] host_addr = 4'd0;
   logic       xfer_stb = 1'b0;
   logic       wr_lock_hi = 1'b0;
   logic [3:0] lane_a_addr, lane_b_addr;
   logic       lane_a_we, lane_b_we, lane_a_oe, lane_b_oe;
   logic [7:0] din_a = 8'h00;
   logic [7:0] din_b = 8'h00;
   logic [7:0] mem [16];

   int checks = 0;
   int errors = 0;

   // captured view of one access
   logic [3:0] c_aa, c_ba;
   logic       c_wa, c_wb, c_oa, c_ob;
   logic [7:0] c_ra, c_rb;

   always #10 clk = ~clk;

   host_port_ctl u0 (
      .clk(clk), .rst_n(rst_n), .host_byte(host_byte), .host_rd(host_rd),
      .pio_en_n(pio_en_n), .dma_en_n(dma_en_n), .host_addr(host_addr),
      .xfer_stb(xfer_stb), .wr_lock_hi(wr_lock_hi),
      .lane_a_addr(lane_a_addr), .lane_b_addr(lane_b_addr),
      .lane_a_we(lane_a_we), .lane_b_we(lane_b_we),
      .lane_a_oe(lane_a_oe), .lane_b_oe(lane_b_oe)
   );

   // bench-side register array
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= 8'hA0 + 8'(i);
      end else begin
         if (lane_a_we) mem[lane_a_addr] <= din_a;
         if (lane_b_we) mem[lane_b_addr] <= din_b;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one access: pn, dn, byte, rd, addr, lock, data A, data B
   task automatic acc(input logic pn, input logic dn, input logic bm, input logic rd,
                      input logic [3:0] ad, input logic lk,
                      input logic [7:0] da, input logic [7:0] db);
      @(negedge clk);
      pio_en_n = pn; dma_en_n = dn; host_byte = bm; host_rd = rd;
      host_addr = ad; wr_lock_hi = lk; din_a = da; din_b = db;
      xfer_stb = !rd;
      #2;
      c_aa = lane_a_addr; c_ba = lane_b_addr;
      c_wa = lane_a_we;   c_wb = lane_b_we;
      c_oa = lane_a_oe;   c_ob = lane_b_oe;
      c_ra = mem[lane_a_addr]; c_rb = mem[lane_b_addr];
      @(negedge clk);
      xfer_stb = 1'b0; pio_en_n = 1'b1; dma_en_n = 1'b1; wr_lock_hi = 1'b0;
   endtask

   task automatic t_reset;
      #1;
      chk("R1", "oe/we in reset", {lane_a_oe, lane_b_oe, lane_a_we, lane_b_we}, 0);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #2;
      chk("R1", "oe/we after reset", {lane_a_oe, lane_b_oe, lane_a_we, lane_b_we}, 0);
   endtask

   task automatic t_disabled;
      acc(1, 1, 0, 0, 4'd4, 0, 8'h11, 8'h22);
      chk("R1", "disabled write enables", {c_wa, c_wb}, 0);
      acc(1, 1, 0, 1, 4'd4, 0, 8'h00, 8'h00);
      chk("R1", "disabled output enables", {c_oa, c_ob}, 0);
      acc(0, 1, 0, 1, 4'd4, 0, 8'h00, 8'h00);
      chk("R1", "byte 4 untouched", c_ra, 8'hA4);
   endtask

   task automatic t_pio_byte;
      acc(0, 1, 1, 0, 4'd5, 0, 8'hEE, 8'h55);
      chk("R3", "odd byte write lanes", {c_wa, c_wb, c_ba}, {1'b0, 1'b1, 4'd5});
      acc(0, 1, 1, 0, 4'd8, 0, 8'h38, 8'hEE);
      chk("R3", "even byte write lanes", {c_wa, c_wb, c_aa}, {1'b1, 1'b0, 4'd8});
      acc(0, 1, 1, 1, 4'd5, 0, 8'h00, 8'h00);
      chk("R3", "odd read lanes", {c_oa, c_ob}, 2'b01);
      chk("R3", "odd read data", c_rb, 8'h55);
      acc(0, 1, 1, 1, 4'd9, 0, 8'h00, 8'h00);
      chk("R3", "byte 9 unchanged", c_rb, 8'hA9);
      acc(0, 1, 1, 1, 4'd8, 0, 8'h00, 8'h00);
      chk("R7", "even read oe", {c_oa, c_ob}, 2'b10);
      chk("R3", "even read data", c_ra, 8'h38);
   endtask

   task automatic t_pio_word;
      acc(0, 1, 0, 0, 4'd7, 0, 8'h66, 8'h77);
      chk("R4", "word write addr A0 ignored", {c_aa, c_ba}, {4'd6, 4'd7});
      chk("R4", "word write both lanes", {c_wa, c_wb}, 2'b11);
      acc(0, 1, 0, 1, 4'd6, 0, 8'h00, 8'h00);
      chk("R4", "word read data", {c_ra, c_rb}, {8'h66, 8'h77});
      chk("R7", "word read oe", {c_oa, c_ob, c_wa, c_wb}, 4'b1100);
      chk("R10", "lane parity", {c_aa[0], c_ba[0]}, 2'b01);
   endtask

   task automatic t_dma_byte;
      acc(1, 0, 1, 0, 4'b1010, 0, 8'hD4, 8'hEE);
      chk("R5", "dma byte A0=0", {c_aa, c_wa, c_wb}, {4'd14, 1'b1, 1'b0});
      acc(1, 0, 1, 0, 4'b0001, 0, 8'hEE, 8'hD5);
      chk("R5", "dma byte A0=1", {c_ba, c_wa, c_wb}, {4'd15, 1'b0, 1'b1});
      acc(1, 0, 1, 1, 4'b0100, 0, 8'h00, 8'h00);
      chk("R5", "dma byte read 14", {c_oa, c_ob, c_ra}, {2'b10, 8'hD4});
   endtask

   task automatic t_dma_word;
      acc(1, 0, 0, 0, 4'b0110, 0, 8'hC2, 8'hC3);
      chk("R6", "dma word A0=0 pair", {c_aa, c_ba, c_wa, c_wb}, {4'd12, 4'd13, 2'b11});
      acc(1, 0, 0, 1, 4'b1001, 0, 8'h00, 8'h00);
      chk("R6", "dma word A0=1 pair", {c_aa, c_ba}, {4'd14, 4'd15});
      chk("R6", "dma word A0=1 data", {c_ra, c_rb}, {8'hD4, 8'hD5});
      acc(0, 1, 0, 1, 4'd12, 0, 8'h00, 8'h00);
      chk("R6", "pair 12/13 content", {c_ra, c_rb}, {8'hC2, 8'hC3});
   endtask

   task automatic t_priority;
      acc(0, 0, 1, 1, 4'b0011, 0, 8'h00, 8'h00);
      chk("R2", "dma wins over pio", {c_ba, c_ob}, {4'd15, 1'b1});
      acc(0, 1, 1, 1, 4'b0011, 0, 8'h00, 8'h00);
      chk("R2", "pio alone addressed", {c_ba, c_ob}, {4'd3, 1'b1});
   endtask

   task automatic t_lock;
      acc(0, 1, 1, 0, 4'd14, 1, 8'h01, 8'h00);
      chk("R9", "locked byte 14 we", {c_wa, c_wb}, 0);
      acc(0, 1, 0, 0, 4'd14, 1, 8'h02, 8'h03);
      chk("R9", "locked pair word we", {c_wa, c_wb}, 0);
      acc(1, 0, 0, 0, 4'd0, 1, 8'h5C, 8'h5D);
      chk("R9", "unlocked pair 12/13 under lock", {c_wa, c_wb}, 2'b11);
      acc(0, 1, 1, 0, 4'd4, 1, 8'h44, 8'h00);
      chk("R9", "byte 4 under lock", c_wa, 1);
      acc(0, 1, 0, 1, 4'd14, 0, 8'h00, 8'h00);
      chk("R9", "pair 14/15 kept", {c_ra, c_rb}, {8'hD4, 8'hD5});
      acc(0, 1, 0, 1, 4'd12, 0, 8'h00, 8'h00);
      chk("R9", "pair 12/13 written", {c_ra, c_rb}, {8'h5C, 8'h5D});
      acc(0, 1, 0, 0, 4'd14, 0, 8'hF4, 8'hF5);
      chk("R9", "pair 14/15 open when unlocked", {c_wa, c_wb}, 2'b11);
   endtask

   task automatic t_held_strobe;
      @(negedge clk);
      pio_en_n = 1'b0; dma_en_n = 1'b1; host_byte = 1'b1; host_rd = 1'b0;
      host_addr = 4'd2; din_a = 8'h12; xfer_stb = 1'b1;
      #2;
      chk("R8", "first strobe cycle we", lane_a_we, 1);
      @(negedge clk); din_a = 8'hBB; #2;
      chk("R8", "held strobe we drops", lane_a_we, 0);
      @(negedge clk); #2;
      chk("R8", "still held, no we", lane_a_we, 0);
      @(negedge clk); xfer_stb = 1'b0; #2;
      chk("R8", "no strobe no we", lane_a_we, 0);
      @(negedge clk); pio_en_n = 1'b1;
      acc(0, 1, 1, 1, 4'd2, 0, 8'h00, 8'h00);
      chk("R8", "byte 2 written once", c_ra, 8'h12);
   endtask

   initial begin
      #4_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_disabled();
      t_pio_byte();
      t_pio_word();
      t_dma_byte();
      t_dma_word();
      t_priority();
      t_lock();
      t_held_strobe();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule